// File: doc/BRIEF.md
# Password Access Controller with Retry Counter

This block decides whether a pending memory operation may go ahead. A requester presents an access mode (read, write or configuration) and a 64-bit candidate key and pulses a compare strobe. One clock later the block answers with either a grant pulse or a deny pulse. The answer comes from comparing the candidate with the stored key for that mode. A configuration grant also raises a flag that opens every array region, whatever restrictions apply to each array.

Failed compares are counted by an 8-bit counter that is measured against an 8-bit limit register. The number of failures still allowed is the limit minus the counter. The counter counts upward and wraps from 255 to 0. If it is loaded above the limit, it therefore runs through the wrap before it reaches the limit. Once the counter equals the limit while counting is enabled, the block is locked out and denies every compare until reset. With counting disabled, failures are only denied and never lead to lockout.

A granted compare can also replace the key of the mode it was made in. The limit, counter and enable fields can be reloaded only by a granted configuration compare. All keys and retry fields return to their parameter defaults on reset.

Top module: `pwd_gate`

## Requirements
- R1: Mode encoding is 0 = read, 1 = write, 2 = configuration, 3 = reserved. A strobe whose key equals the stored key of its mode gives grant one cycle later. A strobe with a mismatching key, or with mode 3, gives deny one cycle later.
- R2: Grant and deny are never high together. Each one is high for exactly the one cycle after a strobe, and both stay low in a cycle that follows no strobe.
- R3: With counting enabled and no lockout, each mismatch increments the retry count by one, modulo 256. A grant leaves the count unchanged.
- R4: Lockout is high exactly when counting is enabled and the count equals the limit, so the number of allowed failures is limit minus count. While lockout is high, every strobe is denied, including one with a correct key, and the count does not change.
- R5: A count loaded above the limit counts up through 255, wraps to 0, and locks when it reaches the limit.
- R6: With counting disabled, mismatches are denied, the count stays frozen and lockout stays low.
- R7: The all-regions flag is high together with grant after a granted configuration compare, and it stays low after read or write grants.
- R8: The limit, count and enable fields are loaded from the configuration inputs only when a configuration compare with its write request is granted. The same request on a read or write grant, or on a denied compare, has no effect.
- R9: A granted compare with its key-change request replaces the stored key of that same mode with the new key, starting from the next strobe. No other mode's key can change a key.
- R10: After reset, grant, deny, all-regions and lockout are low, the count is 0, the limit is LIM_INIT, and counting follows EN_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_req | input | 1 | Compare strobe, one cycle |
| cmp_mode | input | 2 | Access mode of the compare |
| cmp_key | input | 64 | Candidate key |
| set_pw | input | 1 | Replace the key of this mode if granted |
| new_key | input | 64 | Replacement key |
| cfg_wr | input | 1 | Load retry fields if granted in configuration mode |
| cfg_limit | input | 8 | New retry limit |
| cfg_count | input | 8 | New retry count |
| cfg_enable | input | 1 | New retry enable |
| grant | output | 1 | Compare succeeded |
| deny | output | 1 | Compare refused |
| all_regions | output | 1 | Configuration grant, all arrays open |
| lockout | output | 1 | Failure budget used up |
| retry_count | output | 8 | Current retry count |

## Verification
The hardest state to reach from the ports is the wrapped count. From reset the counter only climbs toward the limit, so reaching the wrap takes a count above the limit. The stimulus reaches it with a granted configuration compare that loads a limit of 3 and a count of 250, followed by nine failed compares. The ninth failure must raise lockout, and a correct key must then be refused. The disabled case is built the same way, with count equal to limit and enable low. A later configuration reload that sets enable must lock the block at once.

// File: rtl/pwd_gate_pkg.sv
package pwd_gate_pkg;
    typedef enum logic [1:0] {
        MODE_RD  = 2'd0,
        MODE_WR  = 2'd1,
        MODE_CFG = 2'd2,
        MODE_RSV = 2'd3
    } mode_e;

    localparam int N_KEYS = 3;
endpackage

// File: rtl/pwd_bank.sv
module pwd_bank
    import pwd_gate_pkg::*;
#(
    parameter int               KEY_W = 64,
    parameter logic [KEY_W-1:0] INIT0 = '0,
    parameter logic [KEY_W-1:0] INIT1 = '0,
    parameter logic [KEY_W-1:0] INIT2 = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel_i,
    input  logic [KEY_W-1:0] cand_i,
    input  logic             wr_en_i,
    input  logic [KEY_W-1:0] wr_key_i,
    output logic             match_o
);
    typedef struct packed {
        logic [N_KEYS-1:0][KEY_W-1:0] key;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [N_KEYS-1:0] hit;
    logic [N_KEYS-1:0][KEY_W-1:0] key_nxt;

    generate
        for (genvar g = 0; g < N_KEYS; g++) begin : g_slot
            assign hit[g]     = (bank_q.key[g] == cand_i);
            assign key_nxt[g] = (wr_en_i && sel_i == 2'(g)) ? wr_key_i : bank_q.key[g];
        end
    endgenerate

    always_comb begin
        bank_d.key = key_nxt;
        match_o    = 1'b0;
        for (int i = 0; i < N_KEYS; i++) begin
            if (sel_i == 2'(i)) match_o = hit[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q.key <= {INIT2, INIT1, INIT0};
        else        bank_q     <= bank_d;
    end

    // R9
    key_write_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && sel_i != MODE_RSV) |=> (bank_q.key[$past(sel_i)] == $past(wr_key_i)));
endmodule

// File: rtl/retry_unit.sv
module retry_unit #(
    parameter int             CNT_W    = 8,
    parameter logic [CNT_W-1:0] LIM_INIT = 8'd4,
    parameter logic           EN_INIT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fail_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_lim_i,
    input  logic [CNT_W-1:0] load_cnt_i,
    input  logic             load_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             lock_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             en;
    } retry_t;

    retry_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.cnt = load_cnt_i;
            r_d.lim = load_lim_i;
            r_d.en  = load_en_i;
        end else if (fail_i && r_q.en) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
            r_q.lim <= LIM_INIT;
            r_q.en  <= EN_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o  = r_q.cnt;
    assign lock_o = r_q.en && (r_q.cnt == r_q.lim);

    // R3
    fail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i && r_q.en && !load_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
    // R6
    off_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.en && !load_i) |=> $stable(cnt_o));
    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && !load_i) |=> (lock_o && $stable(cnt_o)));
endmodule

// File: rtl/pwd_gate.sv
module pwd_gate
    import pwd_gate_pkg::*;
#(
    parameter int               KEY_W    = 64,
    parameter int               CNT_W    = 8,
    parameter logic [KEY_W-1:0] RD_INIT  = 64'h1111_2222_3333_4444,
    parameter logic [KEY_W-1:0] WR_INIT  = 64'h5555_6666_7777_8888,
    parameter logic [KEY_W-1:0] CFG_INIT = 64'h9999_AAAA_BBBB_CCCC,
    parameter logic [CNT_W-1:0] LIM_INIT = 8'd4,
    parameter logic             EN_INIT  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_req,
    input  logic [1:0]       cmp_mode,
    input  logic [KEY_W-1:0] cmp_key,
    input  logic             set_pw,
    input  logic [KEY_W-1:0] new_key,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_enable,
    output logic             grant,
    output logic             deny,
    output logic             all_regions,
    output logic             lockout,
    output logic [CNT_W-1:0] retry_count
);
    typedef struct packed {
        logic grant;
        logic deny;
        logic all;
    } verdict_t;

    verdict_t v_d, v_q;
    logic key_match, locked, go, miss, load_cfg, key_wr;

    pwd_bank #(
        .KEY_W (KEY_W),
        .INIT0 (RD_INIT),
        .INIT1 (WR_INIT),
        .INIT2 (CFG_INIT)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (cmp_mode),
        .cand_i   (cmp_key),
        .wr_en_i  (key_wr),
        .wr_key_i (new_key),
        .match_o  (key_match)
    );

    retry_unit #(
        .CNT_W    (CNT_W),
        .LIM_INIT (LIM_INIT),
        .EN_INIT  (EN_INIT)
    ) u_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail_i     (miss),
        .load_i     (load_cfg),
        .load_lim_i (cfg_limit),
        .load_cnt_i (cfg_count),
        .load_en_i  (cfg_enable),
        .cnt_o      (retry_count),
        .lock_o     (locked)
    );

    always_comb begin
        go       = cmp_req && !locked && key_match;
        miss     = cmp_req && !locked && !key_match;
        load_cfg = go && cfg_wr && (cmp_mode == MODE_CFG);
        key_wr   = go && set_pw;
        v_d.grant = go;
        v_d.deny  = cmp_req && !go;
        v_d.all   = go && (cmp_mode == MODE_CFG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign grant       = v_q.grant;
    assign deny        = v_q.deny;
    assign all_regions = v_q.all;
    assign lockout     = locked;

    // R2
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_req |=> (!grant && !deny));
    // R4
    locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && lockout) |=> deny);
    // R7
    all_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_regions |-> grant);
    // R8
    cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cfg_wr && cmp_mode != MODE_CFG) |=>
        (retry_count == $past(retry_count) || retry_count == CNT_W'($past(retry_count) + 1'b1)));
endmodule

// File: tb/pwd_gate_test.sv
`timescale 1ns/1ps
module pwd_gate_test;
    localparam logic [63:0] KR  = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] KW  = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] KC  = 64'h5A5A_A5A5_0F0F_F0F0;
    localparam logic [63:0] KN  = 64'h1357_9BDF_2468_ACE0;
    localparam logic [63:0] KN2 = 64'hDEAD_0000_BEEF_0001;
    localparam logic [63:0] BAD = 64'h0000_0000_0000_0BAD;
    localparam logic [7:0]  LIM0 = 8'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_req = 1'b0;
    logic [1:0] cmp_mode = 2'd0;
    logic [63:0] cmp_key = '0;
    logic set_pw = 1'b0;
    logic [63:0] new_key = '0;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_limit = '0, cfg_count = '0;
    logic cfg_enable = 1'b0;
    logic grant, deny, all_regions, lockout;
    logic [7:0] retry_count;

    always #2.5 clk = ~clk;

    pwd_gate #(
        .RD_INIT (KR), .WR_INIT (KW), .CFG_INIT (KC),
        .LIM_INIT (LIM0), .EN_INIT (1'b1)
    ) uut (
        .clk (clk), .rst_n (rst_n), .cmp_req (cmp_req), .cmp_mode (cmp_mode),
        .cmp_key (cmp_key), .set_pw (set_pw), .new_key (new_key),
        .cfg_wr (cfg_wr), .cfg_limit (cfg_limit), .cfg_count (cfg_count),
        .cfg_enable (cfg_enable), .grant (grant), .deny (deny),
        .all_regions (all_regions), .lockout (lockout), .retry_count (retry_count)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected item: grant, deny, all, lock, count
    logic [11:0] exp_q[$];
    string       tag_q[$];

    logic [63:0] mk [3];
    logic [7:0]  ml, mc;
    logic        me;

    task automatic model_reset();
        mk[0] = KR; mk[1] = KW; mk[2] = KC;
        ml = LIM0; mc = 8'd0; me = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic access(input string tag, input logic [1:0] mode, input logic [63:0] key,
                          input logic sp = 1'b0, input logic [63:0] nk = '0,
                          input logic cw = 1'b0, input logic [7:0] cl = '0,
                          input logic [7:0] cc = '0, input logic ce = 1'b0);
        logic lk, hit, ok;
        lk  = me && (mc == ml);
        hit = (mode != 2'd3) && (key == mk[mode]);
        ok  = !lk && hit;
        if (ok && sp) mk[mode] = nk;
        if (ok && cw && mode == 2'd2) begin
            ml = cl; mc = cc; me = ce;
        end else if (!lk && !hit && me) begin
            mc = mc + 8'd1;
        end
        exp_q.push_back({ok, !ok, ok && (mode == 2'd2), me && (mc == ml), mc});
        tag_q.push_back(tag);
        @(negedge clk);
        cmp_req = 1'b1; cmp_mode = mode; cmp_key = key;
        set_pw = sp; new_key = nk; cfg_wr = cw;
        cfg_limit = cl; cfg_count = cc; cfg_enable = ce;
        @(negedge clk);
        cmp_req = 1'b0; set_pw = 1'b0; cfg_wr = 1'b0;
    endtask

    // monitor
    always @(posedge clk) begin
        logic seen;
        logic [11:0] e, a;
        string t;
        seen = cmp_req && rst_n;
        #2;
        if (seen) begin
            a = {grant, deny, all_regions, lockout, retry_count};
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2: unexpected result g/d/a/l/c=%b", a);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: got g%b d%b a%b l%b cnt=%0d, expected g%b d%b a%b l%b cnt=%0d",
                             t, a[11], a[10], a[9], a[8], a[7:0], e[11], e[10], e[9], e[8], e[7:0]);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run did not end, got timeout, expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        do_reset();
        // R10 reset state
        n_chk++;
        if ({grant, deny, all_regions, lockout, retry_count} !== 12'd0) begin
            n_bad++;
            $display("FAIL R10: got g%b d%b a%b l%b cnt=%0d, expected all zero",
                     grant, deny, all_regions, lockout, retry_count);
        end

        access("R1 read key", 2'd0, KR);
        access("R1 write key", 2'd1, KW);
        access("R7 config key", 2'd2, KC);
        access("R3 cross key", 2'd0, KW);
        access("R1 reserved mode", 2'd3, KC);
        access("R8 cfg on write grant", 2'd1, KW, 1'b0, '0, 1'b1, 8'd9, 8'd9, 1'b0);
        access("R8 cfg on deny", 2'd2, BAD, 1'b0, '0, 1'b1, 8'd9, 8'd0, 1'b0);
        access("R4 last allowed miss", 2'd0, BAD);
        access("R4 good key locked", 2'd0, KR);
        access("R4 config locked", 2'd2, KC);

        do_reset();
        access("R5 load wrap", 2'd2, KC, 1'b0, '0, 1'b1, 8'd3, 8'd250, 1'b1);
        for (int i = 0; i < 9; i++) access("R5 wrap miss", 2'd1, BAD);
        access("R5 locked after wrap", 2'd1, KW);

        do_reset();
        access("R6 disable", 2'd2, KC, 1'b0, '0, 1'b1, 8'd2, 8'd2, 1'b0);
        for (int i = 0; i < 5; i++) access("R6 miss frozen", 2'd0, BAD);
        access("R6 grant still", 2'd0, KR);
        access("R6 enable locks", 2'd2, KC, 1'b0, '0, 1'b1, 8'd2, 8'd2, 1'b1);
        access("R4 locked refuse", 2'd0, KR);

        do_reset();
        access("R9 change read", 2'd0, KR, 1'b1, KN);
        access("R9 old read key", 2'd0, KR);
        access("R9 new read key", 2'd0, KN);
        access("R9 cfg key in write mode", 2'd1, KC, 1'b1, KN2);
        access("R9 write unchanged", 2'd1, KW);
        access("R9 change config", 2'd2, KC, 1'b1, KN2);
        access("R9 old config key", 2'd2, KC);
        access("R9 new config key", 2'd2, KN2);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2: got %0d results missing, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule